// File: doc/BRIEF.md
# Packed String Compare Engine

The engine compares a 128-bit set or pattern operand with a 128-bit text operand under an 8-bit control byte. Both operands are split into sixteen byte elements or eight 16-bit word elements, each read as signed or unsigned. One comparator matrix serves four comparison styles: membership of each text element in a character set, membership in inclusive bound pairs, lane-by-lane equality, and search for the positions where a short pattern starts in the text. After the comparison, an optional polarity flip is applied. The engine then gives both the index of the first or last qualifying text element and a mask, as a compact bit vector or as whole lanes set to all ones.

The length of each operand is given in one of two ways. It can come from its own signed length input, or it can end at the first zero-valued element. Elements at or past the end are invalid, and each comparison style has a fixed rule for invalid elements. Requests enter through a valid/ready handshake. The index, mask and four status flags are registered and held until the consumer takes them.

Top module: `pkstr_match_top`

## Requirements
- R1: Control bits [1:0] select the element format: 00 unsigned byte, 01 unsigned word, 10 signed byte, 11 signed word. Element i of an operand is byte i (bits 8i+7..8i) or word i (bits 16i+15..16i). Signedness sets the ordering used by the bound-pair style.
- R2: Control bits [3:2] = 00 (any-of-set). A valid text element j qualifies when it equals any valid set element.
- R3: Control bits [3:2] = 01 (bound pairs). Set elements 2k and 2k+1 form an inclusive lower and upper bound. A valid text element qualifies when some pair with both bounds valid contains it.
- R4: Control bits [3:2] = 10 (lane equality). Position j qualifies when both elements are valid and equal, or when both are invalid. If only one is valid, it does not qualify.
- R5: Control bits [3:2] = 11 (pattern search). Position j qualifies when, for every pattern element k with j+k below the element count, pattern element k is invalid, or text element j+k is valid and equal to it.
- R6: When use_len is 1, each operand's valid count is the absolute value of its signed length input, capped at the element count (16 bytes or 8 words). The value -128 gives the full count.
- R7: When use_len is 0, an operand ends at its first zero element. That element and all later ones are invalid.
- R8: Control bits [5:4] set polarity. 01 inverts the result of every element. 11 inverts only text elements that are valid. 00 and 10 leave the result unchanged.
- R9: res_index is the lowest qualifying position when control bit 6 is 0, and the highest when it is 1. When no position qualifies, it is 16 for bytes and 8 for words.
- R10: When control bit 6 is 0, res_mask holds one bit per element in its low bits and zeros above. When bit 6 is 1, each qualifying element's whole lane is all ones and the other lanes are zero.
- R11: flag_carry is set when any position qualifies. flag_zero is set when the text operand is shorter than the element count. flag_sign is set when the set operand is shorter than the element count. flag_ovf is the result of position 0.
- R12: in_ready = !out_valid || out_ready. An accepted request shows its result one clock later with out_valid set. While out_valid is 1 and out_ready is 0, the result and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| ctrl | input | 8 | Control byte (format, style, polarity, high/unit select; bit 7 unused) |
| use_len | input | 1 | 1: lengths from set_len/txt_len, 0: zero-terminated |
| set_op | input | 128 | Set, bound-pair or pattern operand |
| txt_op | input | 128 | Text operand |
| set_len | input | 8 | Signed length of the set operand |
| txt_len | input | 8 | Signed length of the text operand |
| out_valid | output | 1 | Registered result present |
| out_ready | input | 1 | Consumer takes the result |
| res_index | output | 5 | Qualifying element index, or element count when none |
| res_mask | output | 128 | Bit mask or lane mask of qualifying elements |
| flag_carry | output | 1 | Any element qualifies |
| flag_zero | output | 1 | Text operand shorter than full |
| flag_sign | output | 1 | Set operand shorter than full |
| flag_ovf | output | 1 | Result of element 0 |

## Verification
The bench runs every value of the low seven control bits, in both length modes, against operands drawn from a small alphabet. The alphabet includes zero, 0x80, 0xFF and repeated letters. Some text operands are the set operand shifted by one word, so that equality, bound and pattern hits actually occur. Random signed lengths from -20 to +20 separate the absolute-value and cap logic from the zero-terminator logic. Directed cases pin down behaviour the sweep could miss: the signed versus unsigned ordering of a bound pair that contains 0x80, the -128 length, a pattern that runs off the end of the text, valid-only inversion in front of a terminator, and stalling of the output register.

// File: rtl/pkstr_pkg.sv
// Package: shared control-byte layout, flag bundle and element widening for
// the packed string compare engine. Assumes elements of 8 or 16 bits.
package pkstr_pkg;

    typedef enum logic [1:0] {
        CMP_ANY   = 2'b00,
        CMP_RANGE = 2'b01,
        CMP_EACH  = 2'b10,
        CMP_ORDER = 2'b11
    } cmp_mode_e;

    typedef enum logic [1:0] {
        POL_KEEP  = 2'b00,
        POL_ALL   = 2'b01,
        POL_KEEP2 = 2'b10,
        POL_VALID = 2'b11
    } pol_e;

    typedef struct packed {
        logic      spare;
        logic      pick_hi;
        pol_e      pol;
        cmp_mode_e mode;
        logic      sgn;
        logic      word;
    } ctrl_t;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic o;
    } flags_t;

    // Widen a raw element to 17 signed bits so one signed compare serves all formats.
    function automatic logic signed [16:0] widen(input logic [15:0] raw,
                                                 input logic is_word,
                                                 input logic is_sgn);
        logic signed [16:0] r;
        if (is_word)
            r = is_sgn ? {raw[15], raw} : {1'b0, raw};
        else
            r = is_sgn ? {{9{raw[7]}}, raw[7:0]} : {9'b0, raw[7:0]};
        return r;
    endfunction

endpackage

// File: rtl/pkstr_lane_valid.sv
// Module: per-operand lane validity. Finds the end of one operand, either
// from a signed length (absolute value, capped at the element count) or at
// the first zero element, and marks the lanes before that end valid.
// Assumes LEN_W >= $clog2(NEL+1).
module pkstr_lane_valid #(
    parameter  int NEL   = 16,
    parameter  int LEN_W = 8,
    localparam int CNT_W = $clog2(NEL + 1),
    localparam int XW    = LEN_W + 1
) (
    input  logic [8*NEL-1:0] op,
    input  logic             word,
    input  logic             use_len,
    input  logic [LEN_W-1:0] len,
    output logic [NEL-1:0]   valid,
    output logic             short_o
);
    localparam int NW = NEL / 2;

    logic [NEL-1:0]       zb;
    logic [NEL-1:0]       zw;
    logic [CNT_W-1:0]     n_el;
    logic [CNT_W-1:0]     term_pos;
    logic [CNT_W-1:0]     len_cap;
    logic [CNT_W-1:0]     limit;
    logic signed [XW-1:0] len_x;
    logic [XW-1:0]        len_abs;

    // Zero detectors for byte lanes and word lanes.
    generate
        for (genvar i = 0; i < NEL; i++) begin : g_zero
            assign zb[i] = (op[8*i +: 8] == 8'h00);
            if (i < NW) begin : g_w
                assign zw[i] = (op[16*i +: 16] == 16'h0000);
            end else begin : g_nw
                assign zw[i] = 1'b0;
            end
        end
    endgenerate

    // Element count of the current format.
    always_comb n_el = word ? CNT_W'(NW) : CNT_W'(NEL);

    // Position of the first zero element; element count when there is none.
    always_comb begin
        term_pos = n_el;
        for (int i = NEL - 1; i >= 0; i--) begin
            if (word ? zw[i] : zb[i]) term_pos = CNT_W'(i);
        end
    end

    // Absolute value of the signed length, one bit wider so -min is exact, then cap.
    always_comb begin
        len_x   = {len[LEN_W-1], len};
        len_abs = len_x[XW-1] ? $unsigned(-len_x) : $unsigned(len_x);
        len_cap = (len_abs >= XW'(n_el)) ? n_el : CNT_W'(len_abs);
    end

    // Choose which end rule applies.
    always_comb limit = use_len ? len_cap : term_pos;

    // Lanes below the end are valid.
    generate
        for (genvar i = 0; i < NEL; i++) begin : g_valid
            assign valid[i] = (CNT_W'(i) < limit);
        end
    endgenerate

    assign short_o = (limit < n_el);

endmodule

// File: rtl/pkstr_cmp_matrix.sv
// Module: comparator matrix and aggregation. Builds every set-versus-text
// equality and bound test, then reduces them per text position with the
// selected style and invalid-element rule. Assumes valid vectors are zero
// above the active element count.
module pkstr_cmp_matrix
    import pkstr_pkg::*;
#(
    parameter int NEL = 16
) (
    input  logic [8*NEL-1:0] set_op,
    input  logic [8*NEL-1:0] txt_op,
    input  logic             word,
    input  logic             sgn,
    input  cmp_mode_e        mode,
    input  logic [NEL-1:0]   set_v,
    input  logic [NEL-1:0]   txt_v,
    output logic [NEL-1:0]   raw
);
    localparam int NW = NEL / 2;

    logic signed [16:0] se [NEL];
    logic signed [16:0] te [NEL];
    logic [NEL-1:0]     eq_m  [NEL];
    logic [NEL-1:0]     ge_m  [NEL];
    logic [NEL-1:0]     le_m  [NEL];
    logic [NEL-1:0]     active;
    logic [NEL-1:0]     agg;

    // Element extraction: word lanes exist only in the lower half of the index range.
    generate
        for (genvar i = 0; i < NEL; i++) begin : g_elem
            if (i < NW) begin : g_both
                assign se[i] = widen(word ? set_op[16*i +: 16] : {8'h00, set_op[8*i +: 8]}, word, sgn);
                assign te[i] = widen(word ? txt_op[16*i +: 16] : {8'h00, txt_op[8*i +: 8]}, word, sgn);
            end else begin : g_byte
                assign se[i] = widen({8'h00, set_op[8*i +: 8]}, 1'b0, sgn);
                assign te[i] = widen({8'h00, txt_op[8*i +: 8]}, 1'b0, sgn);
            end
        end
    endgenerate

    // Lanes that exist in the current format.
    always_comb active = word ? {{(NEL-NW){1'b0}}, {NW{1'b1}}} : {NEL{1'b1}};

    // Full matrix: set element i against text element j.
    always_comb begin
        for (int i = 0; i < NEL; i++) begin
            for (int j = 0; j < NEL; j++) begin
                eq_m[i][j] = (se[i] == te[j]);
                ge_m[i][j] = (te[j] >= se[i]);
                le_m[i][j] = (te[j] <= se[i]);
            end
        end
    end

    // Per text position reduction under the selected style.
    always_comb begin
        agg = '0;
        for (int j = 0; j < NEL; j++) begin
            unique case (mode)
                CMP_ANY: begin
                    for (int i = 0; i < NEL; i++) begin
                        if (set_v[i] && txt_v[j] && eq_m[i][j]) agg[j] = 1'b1;
                    end
                end
                CMP_RANGE: begin
                    for (int k = 0; k < NW; k++) begin
                        if (set_v[2*k] && set_v[2*k+1] && txt_v[j] &&
                            ge_m[2*k][j] && le_m[2*k+1][j]) agg[j] = 1'b1;
                    end
                end
                CMP_EACH: begin
                    if (set_v[j] && txt_v[j]) agg[j] = eq_m[j][j];
                    else                      agg[j] = (set_v[j] == txt_v[j]);
                end
                CMP_ORDER: begin
                    agg[j] = 1'b1;
                    for (int p = j; p < NEL; p++) begin
                        if (active[p] && set_v[p-j]) begin
                            if (!txt_v[p] || !eq_m[p-j][p]) agg[j] = 1'b0;
                        end
                    end
                end
                default: agg[j] = 1'b0;
            endcase
        end
    end

    assign raw = agg & active;

endmodule

// File: rtl/pkstr_extract.sv
// Module: polarity and output extraction. Applies the polarity choice and
// derives the first/last index and the bit or lane mask. Assumes raw is zero
// above the active element count.
module pkstr_extract
    import pkstr_pkg::*;
#(
    parameter  int NEL   = 16,
    localparam int IDX_W = $clog2(NEL + 1)
) (
    input  logic [NEL-1:0]   raw,
    input  logic [NEL-1:0]   txt_v,
    input  pol_e             pol,
    input  logic             pick_hi,
    input  logic             word,
    output logic [NEL-1:0]   res,
    output logic [IDX_W-1:0] index,
    output logic [8*NEL-1:0] mask
);
    localparam int NW = NEL / 2;

    logic [NEL-1:0]   active;
    logic [8*NEL-1:0] bit_m;
    logic [8*NEL-1:0] unit_b;
    logic [8*NEL-1:0] unit_w;

    // Lanes that exist in the current format.
    always_comb active = word ? {{(NEL-NW){1'b0}}, {NW{1'b1}}} : {NEL{1'b1}};

    // Polarity stage.
    always_comb begin
        unique case (pol)
            POL_ALL:   res = raw ^ active;
            POL_VALID: res = raw ^ (txt_v & active);
            default:   res = raw;
        endcase
    end

    // Index: the lowest set position wins unless pick_hi asks for the highest.
    always_comb begin
        index = word ? IDX_W'(NW) : IDX_W'(NEL);
        if (pick_hi) begin
            for (int i = 0; i < NEL; i++) if (res[i]) index = IDX_W'(i);
        end else begin
            for (int i = NEL - 1; i >= 0; i--) if (res[i]) index = IDX_W'(i);
        end
    end

    // Compact mask and the two lane-expanded masks.
    assign bit_m = {{(8*NEL-NEL){1'b0}}, res};
    generate
        for (genvar i = 0; i < NEL; i++) begin : g_unit_b
            assign unit_b[8*i +: 8] = {8{res[i]}};
        end
        for (genvar i = 0; i < NW; i++) begin : g_unit_w
            assign unit_w[16*i +: 16] = {16{res[i]}};
        end
    endgenerate

    // Mask form selection.
    always_comb mask = !pick_hi ? bit_m : (word ? unit_w : unit_b);

endmodule

// File: rtl/pkstr_match_top.sv
// Module: packed string compare engine top. Decodes the control byte, finds
// lane validity for both operands, runs the comparator matrix, extracts index
// and mask, and registers result plus flags behind a valid/ready handshake.
// Assumes OP_W is a multiple of 16 and LEN_W >= $clog2(OP_W/8+1).
module pkstr_match_top
    import pkstr_pkg::*;
#(
    parameter  int OP_W  = 128,
    parameter  int LEN_W = 8,
    localparam int NEL   = OP_W / 8,
    localparam int IDX_W = $clog2(NEL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       ctrl,
    input  logic             use_len,
    input  logic [OP_W-1:0]  set_op,
    input  logic [OP_W-1:0]  txt_op,
    input  logic [LEN_W-1:0] set_len,
    input  logic [LEN_W-1:0] txt_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] res_index,
    output logic [OP_W-1:0]  res_mask,
    output logic             flag_carry,
    output logic             flag_zero,
    output logic             flag_sign,
    output logic             flag_ovf
);
    ctrl_t            cb;
    logic             ctrl_unused;
    logic [NEL-1:0]   set_v;
    logic [NEL-1:0]   txt_v;
    logic             set_short;
    logic             txt_short;
    logic [NEL-1:0]   raw;
    logic [NEL-1:0]   res;
    logic [IDX_W-1:0] idx_c;
    logic [OP_W-1:0]  mask_c;
    flags_t           fl_c;
    flags_t           fl_q;

    assign cb          = ctrl_t'(ctrl);
    assign ctrl_unused = cb.spare;

    pkstr_lane_valid #(.NEL(NEL), .LEN_W(LEN_W)) u_set_valid (
        .op      (set_op),
        .word    (cb.word),
        .use_len (use_len),
        .len     (set_len),
        .valid   (set_v),
        .short_o (set_short)
    );

    pkstr_lane_valid #(.NEL(NEL), .LEN_W(LEN_W)) u_txt_valid (
        .op      (txt_op),
        .word    (cb.word),
        .use_len (use_len),
        .len     (txt_len),
        .valid   (txt_v),
        .short_o (txt_short)
    );

    pkstr_cmp_matrix #(.NEL(NEL)) u_matrix (
        .set_op (set_op),
        .txt_op (txt_op),
        .word   (cb.word),
        .sgn    (cb.sgn),
        .mode   (cb.mode),
        .set_v  (set_v),
        .txt_v  (txt_v),
        .raw    (raw)
    );

    pkstr_extract #(.NEL(NEL)) u_extract (
        .raw     (raw),
        .txt_v   (txt_v),
        .pol     (cb.pol),
        .pick_hi (cb.pick_hi),
        .word    (cb.word),
        .res     (res),
        .index   (idx_c),
        .mask    (mask_c)
    );

    // Status flags from the final result and the two length conditions.
    always_comb begin
        fl_c.c = |res;
        fl_c.z = txt_short;
        fl_c.s = set_short;
        fl_c.o = res[0];
    end

    // Output register accepts when empty or when being drained.
    assign in_ready = !out_valid || out_ready;

    // Result register and valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_index <= '0;
            res_mask  <= '0;
            fl_q      <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            res_index <= idx_c;
            res_mask  <= mask_c;
            fl_q      <= fl_c;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign flag_carry = fl_q.c;
    assign flag_zero  = fl_q.z;
    assign flag_sign  = fl_q.s;
    assign flag_ovf   = fl_q.o;

endmodule

// File: rtl/pkstr_match_chk.sv
// Module: property checker for the packed string compare engine, bound to
// every instance of the top. Observes ports only.
module pkstr_match_chk #(
    parameter int OP_W  = 128,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] res_index,
    input logic [OP_W-1:0]  res_mask,
    input logic             flag_carry,
    input logic             flag_zero,
    input logic             flag_sign,
    input logic             flag_ovf
);
    localparam int NEL = OP_W / 8;

    p_accept_loads_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_idle_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    p_stall_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(res_index) && $stable(res_mask)
            && $stable({flag_carry, flag_zero, flag_sign, flag_ovf}));

    p_ovf_in_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && flag_ovf |-> flag_carry);

    p_nohit_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !flag_carry |->
            (res_index == IDX_W'(NEL) || res_index == IDX_W'(NEL/2)) && res_mask == '0);

    p_hit_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && flag_carry |-> res_index < IDX_W'(NEL) && res_mask != '0);

endmodule

bind pkstr_match_top pkstr_match_chk #(.OP_W(OP_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .res_index  (res_index),
    .res_mask   (res_mask),
    .flag_carry (flag_carry),
    .flag_zero  (flag_zero),
    .flag_sign  (flag_sign),
    .flag_ovf   (flag_ovf)
);

// File: tb/pkstr_match_top_tb_top.sv
// Bench: sweeps every control value in both length modes against generated
// operands, compares with an arithmetic model, then runs directed corners.
module pkstr_match_top_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   ctrl = '0;
    logic         use_len = 1'b0;
    logic [127:0] set_op = '0;
    logic [127:0] txt_op = '0;
    logic [7:0]   set_len = '0;
    logic [7:0]   txt_len = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [4:0]   res_index;
    logic [127:0] res_mask;
    logic         flag_carry, flag_zero, flag_sign, flag_ovf;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    pkstr_match_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .ctrl(ctrl), .use_len(use_len), .set_op(set_op), .txt_op(txt_op),
        .set_len(set_len), .txt_len(txt_len), .out_valid(out_valid),
        .out_ready(out_ready), .res_index(res_index), .res_mask(res_mask),
        .flag_carry(flag_carry), .flag_zero(flag_zero), .flag_sign(flag_sign),
        .flag_ovf(flag_ovf)
    );

    function automatic logic [3:0] flags_now();
        return {flag_carry, flag_zero, flag_sign, flag_ovf};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s ctrl=%h use_len=%0d actual=%h expected=%h", tag, ctrl, use_len, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    // Element value as an integer under the selected format.
    function automatic int elv(logic [127:0] op, int i, bit w, bit s);
        int v;
        if (w) begin
            v = int'(op[16*i +: 16]);
            if (s && v >= 32768) v -= 65536;
        end else begin
            v = int'(op[8*i +: 8]);
            if (s && v >= 128) v -= 256;
        end
        return v;
    endfunction

    function automatic int count_of(logic [127:0] op, bit w, bit ul, logic [7:0] len);
        int n = w ? 8 : 16;
        int l;
        if (ul) begin
            l = int'($signed(len));
            if (l < 0) l = -l;
            return (l > n) ? n : l;
        end
        for (int i = 0; i < n; i++) if (elv(op, i, w, 1'b0) == 0) return i;
        return n;
    endfunction

    // Arithmetic model of the requirements.
    task automatic model(input logic [7:0] c, input bit ul, input logic [127:0] s, input logic [127:0] t,
                         input logic [7:0] sl, input logic [7:0] tl,
                         output int idx, output logic [127:0] m, output logic [3:0] f);
        bit w = c[0];
        bit sg = c[1];
        int md = int'(c[3:2]);
        int pl = int'(c[5:4]);
        bit hi = c[6];
        int n = w ? 8 : 16;
        int ls = count_of(s, w, ul, sl);
        int lt = count_of(t, w, ul, tl);
        bit r [16];
        bit any = 1'b0;
        for (int j = 0; j < 16; j++) r[j] = 1'b0;
        for (int j = 0; j < n; j++) begin
            case (md)
                0: for (int i = 0; i < ls; i++)
                       if (j < lt && elv(s, i, w, sg) == elv(t, j, w, sg)) r[j] = 1'b1;
                1: for (int k = 0; 2*k+1 < ls; k++)
                       if (j < lt && elv(s, 2*k, w, sg) <= elv(t, j, w, sg)
                                  && elv(t, j, w, sg) <= elv(s, 2*k+1, w, sg)) r[j] = 1'b1;
                2: begin
                       if (j < ls && j < lt) r[j] = (elv(s, j, w, sg) == elv(t, j, w, sg));
                       else r[j] = ((j < ls) == (j < lt));
                   end
                default: begin
                       r[j] = 1'b1;
                       for (int k = 0; j + k < n; k++)
                           if (k < ls && (j + k >= lt || elv(s, k, w, sg) != elv(t, j+k, w, sg))) r[j] = 1'b0;
                   end
            endcase
            if (pl == 1) r[j] = !r[j];
            if (pl == 3 && j < lt) r[j] = !r[j];
        end
        idx = n;
        m = '0;
        for (int j = 0; j < n; j++) begin
            if (r[j]) any = 1'b1;
            if (hi) begin
                if (r[j]) idx = j;
                if (w) m[16*j +: 16] = {16{r[j]}};
                else   m[8*j +: 8]   = {8{r[j]}};
            end else begin
                m[j] = r[j];
            end
        end
        if (!hi) for (int j = n - 1; j >= 0; j--) if (r[j]) idx = j;
        f = {any, lt < n, ls < n, r[0]};
    endtask

    task automatic send(input logic [7:0] c, input bit ul, input logic [127:0] s, input logic [127:0] t,
                        input logic [7:0] sl, input logic [7:0] tl);
        @(negedge clk);
        ctrl = c; use_len = ul; set_op = s; txt_op = t; set_len = sl; txt_len = tl;
        in_valid = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [7:0] pick_byte(logic [31:0] r);
        case (r[2:0])
            3'd0: return r[3] ? 8'h00 : 8'h61;
            3'd1: return 8'h61;
            3'd2: return 8'h62;
            3'd3: return 8'h63;
            3'd4: return 8'h80;
            3'd5: return 8'hFF;
            3'd6: return 8'h30;
            default: return 8'h7F;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R12 watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int eidx;
        logic [127:0] em;
        logic [3:0] ef;
        logic [127:0] s, t, a_mask;
        logic [4:0] a_idx;
        string mtag;

        repeat (3) @(negedge clk);
        // Reset state (R12).
        chk("R12 reset out_valid", 128'(out_valid), 128'(0));
        chk("R12 reset in_ready", 128'(in_ready), 128'(1));
        chk("R12 reset index", 128'(res_index), 128'(0));
        rst_n = 1'b1;

        // Sweep of every control value, both length modes (R2..R5, R9..R11).
        for (int c = 0; c < 128; c++) begin
            for (int ul = 0; ul < 2; ul++) begin
                for (int p = 0; p < 6; p++) begin
                    for (int b = 0; b < 16; b++) s[8*b +: 8] = pick_byte(rnd());
                    if (p[0]) t = {s[15:0], s[127:16]};
                    else for (int b = 0; b < 16; b++) t[8*b +: 8] = pick_byte(rnd());
                    if (p == 2) t = s;
                    set_len = 8'(int'(rnd() % 41) - 20);
                    txt_len = 8'(int'(rnd() % 41) - 20);
                    model(8'(c), ul[0], s, t, set_len, txt_len, eidx, em, ef);
                    send(8'(c), ul[0], s, t, set_len, txt_len);
                    case (c[3:2])
                        2'd0: mtag = "R2";
                        2'd1: mtag = "R3";
                        2'd2: mtag = "R4";
                        default: mtag = "R5";
                    endcase
                    chk({mtag, " R9 index"}, 128'(res_index), 128'(eidx));
                    chk({mtag, " R10 mask"}, res_mask, em);
                    chk({mtag, " R11 flags"}, 128'(flags_now()), 128'(ef));
                end
            end
        end

        // R1: 0x80 lies inside [0x10,0x90] unsigned, signed pair is empty.
        s = '0; s[7:0] = 8'h10; s[15:8] = 8'h90;
        t = {16{8'h05}}; t[7:0] = 8'h80;
        send(8'h04, 1'b1, s, t, 8'd2, 8'd16);
        chk("R1 unsigned range index", 128'(res_index), 128'(0));
        send(8'h06, 1'b1, s, t, 8'd2, 8'd16);
        chk("R1 signed range index", 128'(res_index), 128'(16));

        // R6: length -128 gives full set; lane equality inverted finds lane 5.
        s = {16{8'h61}};
        send(8'h18, 1'b1, s, s, 8'h80, 8'd5);
        chk("R6 neg-min length index", 128'(res_index), 128'(5));
        chk("R6 neg-min length flags", 128'(flags_now()), 128'(4'b1100));
        send(8'h18, 1'b1, s, s, 8'hFD, 8'd100);
        chk("R6 abs and cap index", 128'(res_index), 128'(3));
        chk("R6 abs and cap flags", 128'(flags_now()), 128'(4'b1010));

        // R7: terminator at lane 2 hides the 'c' at lane 3.
        s = '0; s[7:0] = 8'h63;
        t = {16{8'h63}}; t[7:0] = 8'h61; t[15:8] = 8'h62; t[23:16] = 8'h00;
        send(8'h00, 1'b0, s, t, 8'd0, 8'd0);
        chk("R7 hidden after terminator", 128'(res_index), 128'(16));
        chk("R7 flags", 128'(flags_now()), 128'(4'b0110));
        s[7:0] = 8'h62;
        send(8'h00, 1'b0, s, t, 8'd0, 8'd0);
        chk("R7 hit before terminator", 128'(res_index), 128'(1));

        // R8: valid-only inversion versus full inversion, unit byte masks.
        s = '0; s[7:0] = 8'h78;
        t = '0; t[7:0] = 8'h61; t[15:8] = 8'h62;
        send(8'h70, 1'b0, s, t, 8'd0, 8'd0);
        chk("R8 valid-only index", 128'(res_index), 128'(1));
        chk("R8 valid-only mask", res_mask, 128'hFFFF);
        send(8'h50, 1'b0, s, t, 8'd0, 8'd0);
        chk("R8 full inversion index", 128'(res_index), 128'(15));
        chk("R8 full inversion mask", res_mask, {128{1'b1}});

        // R9: word format with no hit reports 8.
        send(8'h01, 1'b1, {8{16'h1111}}, {8{16'h2222}}, 8'd8, 8'd8);
        chk("R9 word no-hit index", 128'(res_index), 128'(8));
        chk("R9 word no-hit mask", res_mask, 128'h0);

        // R10: word lane equality, unit mask clears only lane 2.
        s = {8{16'h4142}}; t = s; t[47:32] = 16'h0001;
        send(8'h49, 1'b1, s, t, 8'd8, 8'd8);
        chk("R10 word unit mask", res_mask, ~(128'hFFFF << 32));
        chk("R10 word unit index", 128'(res_index), 128'(7));

        // R5: pattern "ab" at lanes 1 and 4, partial at lane 15.
        s = '0; s[7:0] = 8'h61; s[15:8] = 8'h62;
        t = {16{8'h78}}; t[15:8] = 8'h61; t[23:16] = 8'h62; t[39:32] = 8'h61; t[47:40] = 8'h62;
        t[127:120] = 8'h61;
        send(8'h0C, 1'b1, s, t, 8'd2, 8'd16);
        chk("R5 pattern mask", res_mask, 128'h8012);
        chk("R5 pattern index", 128'(res_index), 128'(1));

        // R12: stall holds the first result; second request waits.
        @(negedge clk);
        out_ready = 1'b0;
        ctrl = 8'h01; use_len = 1'b1; set_op = {8{16'h1111}}; txt_op = {8{16'h2222}};
        set_len = 8'd8; txt_len = 8'd8; in_valid = 1'b1;
        @(negedge clk);
        chk("R12 loaded after one cycle", 128'(out_valid), 128'(1));
        chk("R12 not ready while stalled", 128'(in_ready), 128'(0));
        a_idx = res_index; a_mask = res_mask;
        ctrl = 8'h00; set_op = {16{8'h61}}; txt_op = {16{8'h61}}; set_len = 8'd16; txt_len = 8'd16;
        repeat (2) @(negedge clk);
        chk("R12 held index", 128'(res_index), 128'(a_idx));
        chk("R12 held value", 128'(res_index), 128'(8));
        chk("R12 held mask", res_mask, a_mask);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 next taken index", 128'(res_index), 128'(0));
        @(negedge clk);
        chk("R12 drains", 128'(out_valid), 128'(0));

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule